// File: doc/BRIEF.md
# Shared message-signaled interrupt bank

This block holds a small set of shared interrupt registers that collect message-signaled interrupts. When an agent writes a code to the index register, the block sets a single bit in one shared register. Each shared register drives its own level interrupt line for as long as it holds any set bit. A handler reads the shared register to learn which messages arrived. The read returns the accumulated bits and empties the register in the same cycle, so the line drops. A summary register shows at a glance which shared registers are non-empty.

The register port has separate read and write addresses, so a message can arrive in the same cycle that a handler drains a register. Read data is registered and appears one cycle after the read strobe. With the default parameters there are eight 32-bit shared registers at word addresses 0 to 7, the summary at address 8 and the index register at address 9. Every other address reads as zero.

Top module: `msi_share_bank`

## Requirements
- R1: An index write (write strobe with write address 9) sets bit `wdata[4:0]` of shared register `wdata[7:5]`. The change is visible from the next cycle, and every other bit of the bank is unchanged.
- R2: A read of address i (0 to 7) returns shared register i's contents on `rdata` one cycle after the read strobe, and leaves that register all zero.
- R3: `irq[i]` is high in exactly the cycles where shared register i is non-zero, so it falls in the cycle after the read that empties it.
- R4: A read of address 8 returns, one cycle later, bit i set for each non-empty shared register i, with all bits above 7 zero.
- R5: Writes to any address other than 9 (shared registers, summary, unused addresses) change no shared register.
- R6: If an index write sets a bit in a register that is being read in the same cycle, the read returns the old contents and the register then holds only the new bit.
- R7: Reads of the index register and of addresses 10 to 15 return zero.
- R8: Synchronous active-high reset clears all shared registers, `irq` and `rdata`. In cycles without a read strobe, `rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W (4) | Write word address |
| wdata | input | REG_W (32) | Write data; for the index register, select in [7:5] and bit position in [4:0] |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W (4) | Read word address |
| rdata | output | REG_W (32) | Registered read data, valid one cycle after `rd_en` |
| irq | output | NUM_REGS (8) | One level interrupt per shared register |

## Verification
The bench builds the block with its default values: eight 32-bit registers and a 4-bit address. This geometry makes every register select reachable, along with both end bit positions 0 and 31, the summary address, the index address and the six unused addresses. These parameters also allow a read and an index write to collide on the same register. A seeded random phase mixes index writes, stray writes and reads to all sixteen addresses, and each read and each interrupt line is compared with a reference model that clears before it sets.

// File: rtl/msi_bank_pkg.sv
package msi_bank_pkg;

  typedef enum logic [1:0] {
    ACC_SHARE   = 2'd0,
    ACC_SUMMARY = 2'd1,
    ACC_INDEX   = 2'd2,
    ACC_NONE    = 2'd3
  } acc_kind_e;

  // Word map: shared registers first, then summary, then index.
  function automatic acc_kind_e decode_addr(input int unsigned a,
                                            input int unsigned nregs);
    if (a < nregs)            return ACC_SHARE;
    else if (a == nregs)      return ACC_SUMMARY;
    else if (a == nregs + 1)  return ACC_INDEX;
    else                      return ACC_NONE;
  endfunction

endpackage

// File: rtl/msi_index_decode.sv
module msi_index_decode #(
  parameter int NUM_REGS = 8,
  parameter int REG_W    = 32
) (
  input  logic                           idx_wr,
  input  logic [REG_W-1:0]               wdata,
  output logic [NUM_REGS-1:0][REG_W-1:0] set_mask
);
  localparam int SEL_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam int POS_W = $clog2(REG_W);

  logic [SEL_W-1:0] sel;
  logic [POS_W-1:0] pos;
  logic [REG_W-1:0] onehot;

  assign sel    = wdata[POS_W+SEL_W-1:POS_W];
  assign pos    = wdata[POS_W-1:0];
  assign onehot = REG_W'(1) << pos;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_mask
    assign set_mask[g] = (idx_wr && (sel == SEL_W'(g))) ? onehot : '0;
  end
endmodule

// File: rtl/msi_share_reg.sv
module msi_share_reg #(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [REG_W-1:0] set_bits,
  output logic [REG_W-1:0] word,
  output logic             irq
);
  logic [REG_W-1:0] word_nxt;

  // Clear first, then merge the new message so it survives a collision.
  always_comb begin
    word_nxt = (clr ? '0 : word) | set_bits;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word <= '0;
      irq  <= 1'b0;
    end else begin
      word <= word_nxt;
      irq  <= |word_nxt;
    end
  end
endmodule

// File: rtl/msi_read_mux.sv
module msi_read_mux
  import msi_bank_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int REG_W    = 32
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           rd_en,
  input  acc_kind_e                      kind,
  input  logic [$clog2(NUM_REGS > 1 ? NUM_REGS : 2)-1:0] sel,
  input  logic [NUM_REGS-1:0][REG_W-1:0] words,
  output logic [REG_W-1:0]               rdata
);
  logic [REG_W-1:0] summary;
  logic [REG_W-1:0] pick;

  always_comb begin
    summary = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      summary[i] = |words[i];
    end
  end

  always_comb begin
    unique case (kind)
      ACC_SHARE:   pick = words[sel];
      ACC_SUMMARY: pick = summary;
      default:     pick = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= pick;
    else            rdata <= '0;
  end
endmodule

// File: rtl/msi_share_bank.sv
module msi_share_bank
  import msi_bank_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int REG_W    = 32,
  parameter int ADDR_W   = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [REG_W-1:0]    wdata,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [REG_W-1:0]    rdata,
  output logic [NUM_REGS-1:0] irq
);
  localparam int SEL_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  acc_kind_e                      wr_kind;
  acc_kind_e                      rd_kind;
  logic                           idx_wr;
  logic [SEL_W-1:0]               rd_sel;
  logic [NUM_REGS-1:0][REG_W-1:0] set_mask;
  logic [NUM_REGS-1:0][REG_W-1:0] words;

  assign wr_kind = decode_addr(int'(wr_addr), NUM_REGS);
  assign rd_kind = decode_addr(int'(rd_addr), NUM_REGS);
  assign idx_wr  = wr_en && (wr_kind == ACC_INDEX);
  assign rd_sel  = rd_addr[SEL_W-1:0];

  msi_index_decode #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_dec (
    .idx_wr   (idx_wr),
    .wdata    (wdata),
    .set_mask (set_mask)
  );

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_bank
    logic clr_g;
    assign clr_g = rd_en && (rd_kind == ACC_SHARE) && (rd_sel == SEL_W'(g));
    msi_share_reg #(.REG_W(REG_W)) u_reg (
      .clk      (clk),
      .rst      (rst),
      .clr      (clr_g),
      .set_bits (set_mask[g]),
      .word     (words[g]),
      .irq      (irq[g])
    );
  end

  msi_read_mux #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_rmux (
    .clk   (clk),
    .rst   (rst),
    .rd_en (rd_en),
    .kind  (rd_kind),
    .sel   (rd_sel),
    .words (words),
    .rdata (rdata)
  );
endmodule

// File: rtl/msi_share_bank_chk.sv
module msi_share_bank_chk #(
  parameter int NUM_REGS = 8,
  parameter int REG_W    = 32,
  parameter int ADDR_W   = 4
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           wr_en,
  input logic [ADDR_W-1:0]              wr_addr,
  input logic [REG_W-1:0]               wdata,
  input logic                           rd_en,
  input logic [ADDR_W-1:0]              rd_addr,
  input logic [REG_W-1:0]               rdata,
  input logic [NUM_REGS-1:0]            irq,
  input logic [NUM_REGS-1:0][REG_W-1:0] words
);
  localparam int SEL_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam int POS_W = $clog2(REG_W);
  localparam int SUM_A = NUM_REGS;
  localparam int IDX_A = NUM_REGS + 1;

  logic             idx_wr;
  logic [SEL_W-1:0] wsel;
  logic [POS_W-1:0] wpos;
  logic [SEL_W-1:0] rsel;
  logic             rd_share;

  assign idx_wr   = wr_en && (int'(wr_addr) == IDX_A);
  assign wsel     = wdata[POS_W+SEL_W-1:POS_W];
  assign wpos     = wdata[POS_W-1:0];
  assign rsel     = rd_addr[SEL_W-1:0];
  assign rd_share = rd_en && (int'(rd_addr) < NUM_REGS);

  p_set_bit_r1: assert property (@(posedge clk) disable iff (rst)
    (idx_wr && int'(wsel) < NUM_REGS) |=> words[$past(wsel)][$past(wpos)]);

  p_read_value_r2: assert property (@(posedge clk) disable iff (rst)
    rd_share |=> rdata == $past(words[rsel]));

  p_read_clear_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_share && !(idx_wr && wsel == rsel)) |=> words[$past(rsel)] == '0);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_lvl
    p_irq_level_r3: assert property (@(posedge clk) disable iff (rst)
      irq[g] == (words[g] != '0));
  end

  p_summary_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && int'(rd_addr) == SUM_A) |=> rdata == REG_W'($past(irq)));

  p_ignore_wr_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !idx_wr && !rd_en) |=> $stable(words));

  p_keep_new_r6: assert property (@(posedge clk) disable iff (rst)
    (idx_wr && rd_share && wsel == rsel) |=> words[$past(wsel)] == (REG_W'(1) << $past(wpos)));

  p_oob_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && int'(rd_addr) > SUM_A) |=> rdata == '0);

  p_reset_clear_r8: assert property (@(posedge clk)
    rst |=> (words == '0 && irq == '0 && rdata == '0));
endmodule

bind msi_share_bank msi_share_bank_chk #(
  .NUM_REGS (NUM_REGS),
  .REG_W    (REG_W),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wdata   (wdata),
  .rd_en   (rd_en),
  .rd_addr (rd_addr),
  .rdata   (rdata),
  .irq     (irq),
  .words   (words)
);

// File: tb/sim_msi_share_bank.sv
`timescale 1ns/1ps
module sim_msi_share_bank;
  localparam int NR  = 8;
  localparam int RW  = 32;
  localparam int AW  = 4;
  localparam int SUM = 8;
  localparam int IDX = 9;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [RW-1:0] wdata = '0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [RW-1:0] rdata;
  logic [NR-1:0] irq;

  always #2.5 clk = ~clk;

  msi_share_bank #(.NUM_REGS(NR), .REG_W(RW), .ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wdata(wdata),
    .rd_en(rd_en), .rd_addr(rd_addr), .rdata(rdata), .irq(irq)
  );

  int            n_chk  = 0;
  int            n_fail = 0;
  bit            ended  = 0;
  logic [RW-1:0] mdl [NR];
  logic [RW-1:0] exp_q [$];
  string         tag_q [$];

  task automatic check(input string tag, input logic [RW-1:0] act,
                       input logic [RW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [RW-1:0] mdl_summary();
    logic [RW-1:0] s = '0;
    for (int i = 0; i < NR; i++) s[i] = (mdl[i] != '0);
    return s;
  endfunction

  // Driver: called just after a falling edge; predicts the read result
  // and the post-edge bank, then waits one full cycle.
  task automatic step(input bit wr, input logic [AW-1:0] wa,
                      input logic [RW-1:0] wd, input bit rd,
                      input logic [AW-1:0] ra, input string tag);
    logic [RW-1:0] e;
    wr_en = wr; wr_addr = wa; wdata = wd;
    rd_en = rd; rd_addr = ra;
    if (rd) begin
      if (int'(ra) < NR)        e = mdl[ra];
      else if (int'(ra) == SUM) e = mdl_summary();
      else                      e = '0;
      exp_q.push_back(e);
      tag_q.push_back(tag);
      if (int'(ra) < NR) mdl[ra] = '0;
    end
    if (wr && int'(wa) == IDX) mdl[wd[7:5]][wd[4:0]] = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic post(input int r, input int p);
    step(1'b1, AW'(IDX), RW'((r << 5) | p), 1'b0, '0, "R1");
  endtask

  task automatic rd(input int a, input string tag);
    step(1'b0, '0, '0, 1'b1, AW'(a), tag);
  endtask

  // Monitor: one time unit after each rising edge, compare results.
  always @(posedge clk) begin
    bit was_rd;
    logic [RW-1:0] e;
    string t;
    was_rd = rd_en;
    #1;
    if (!rst && !ended) begin
      if (was_rd) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, rdata, e);
      end else begin
        check("R8", rdata, '0);
      end
      check("R3", RW'(irq), mdl_summary());
    end
  end

  initial begin
    for (int i = 0; i < NR; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    check("R8", rdata, '0);
    check("R8", RW'(irq), '0);
    rst = 1'b0;
    // R8: everything empty after reset
    for (int a = 0; a < 16; a++) rd(a, "R8");

    // R1 / R2 / R3: single message, read back, line drops
    post(3, 7);
    rd(3, "R2");
    rd(3, "R2");

    // R1: both end bit positions on the top register, R4 summary
    post(7, 0);
    post(7, 31);
    post(0, 12);
    rd(SUM, "R4");
    rd(7, "R2");
    rd(SUM, "R4");
    rd(0, "R2");

    // R5: stray writes to shared, summary and unused addresses
    step(1'b1, AW'(2), 32'hFFFF_FFFF, 1'b0, '0, "R5");
    step(1'b1, AW'(SUM), 32'hFFFF_FFFF, 1'b0, '0, "R5");
    step(1'b1, AW'(13), 32'h0000_00E5, 1'b0, '0, "R5");
    rd(2, "R5");
    rd(SUM, "R5");

    // R6: message lands while the same register is being drained
    post(5, 4);
    step(1'b1, AW'(IDX), RW'((5 << 5) | 9), 1'b1, AW'(5), "R6");
    rd(5, "R6");
    // read one register while posting to another
    post(1, 2);
    step(1'b1, AW'(IDX), RW'((6 << 5) | 30), 1'b1, AW'(1), "R2");
    rd(6, "R2");

    // R7: index and unused addresses read zero while bank is busy
    post(4, 1);
    rd(IDX, "R7");
    rd(10, "R7");
    rd(15, "R7");
    rd(4, "R2");

    // Mixed random traffic
    for (int n = 0; n < 400; n++) begin
      bit w = ($urandom % 3) != 0;
      bit r = ($urandom % 2) != 0;
      logic [AW-1:0] wa = (($urandom % 4) == 0) ? AW'($urandom) : AW'(IDX);
      step(w, wa, $urandom, r, AW'($urandom), "R2");
    end
    for (int a = 0; a < NR; a++) rd(a, "R2");
    rd(SUM, "R4");

    repeat (2) @(negedge clk);
    check("R2", RW'(exp_q.size()), '0);
    ended = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(100000 * 5);
    if (!ended) begin
      ended = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule